// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector with Digital Lock Filter

This block compares a divided oscillator pulse train (the feedback input) against a divided reference pulse train. Both inputs are sampled on a fast system clock, and only their rising transitions matter. When the reference edge arrives first, the active-low `up_n` output goes low until the matching feedback edge arrives. This requests a higher oscillator frequency. When the feedback edge arrives first, `dn_n` goes low until the reference edge arrives. This requests a lower frequency. The low time in clock cycles equals the measured edge offset.

Edges that arrive in the same sample cycle cancel at once, so no pulse is produced. A raw activity signal is the NAND of the two active-low outputs. A digital filter follows it and produces a lock flag:

- A comparison period runs from one detected reference edge to the next.
- The flag rises after a programmable number of consecutive periods with no pulse activity.
- The flag falls as soon as any single pulse stays low longer than a programmable width limit.

Top module: `pfd_lock_top`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to a defined state. After that edge, `up_n` and `dn_n` are 1, `act_raw` is 0 and `locked` is 0.
- R2: A pulse starts only on a 0-to-1 transition of an input between two samples. An input held high starts nothing more.
- R3: If a reference rise is sampled d cycles before a feedback rise (d ≥ 1), `up_n` is low for exactly d cycles. It goes low in the cycle after the reference rise is sampled, and `dn_n` stays 1.
- R4: If a feedback rise is sampled d cycles before a reference rise, `dn_n` is low for exactly d cycles, and `up_n` stays 1.
- R5: Rises sampled in the same cycle produce no pulse. `up_n` and `dn_n` are never low together.
- R6: Extra edges on the input that opened a pulse neither end nor restart it. The pulse lasts until the other input rises, which covers a frequency error as well as a phase error.
- R7: `act_raw` equals NOT(`up_n` AND `dn_n`) in every cycle.
- R8: Each sampled reference rise closes a comparison period. A period is quiet if `act_raw` was 0 in every cycle since the previous sampled reference rise, including the closing cycle. The first period is measured from reset. `locked` becomes 1 in the cycle after the rise that closes the `quiet_need`-th consecutive quiet period. A `quiet_need` of 0 acts as 1.
- R9: `locked` becomes 0 in the cycle after the (`wide_limit`+1)-th consecutive cycle of `act_raw` = 1, and the quiet count restarts. Pulses no longer than `wide_limit` leave `locked` unchanged.
- R10: If a width violation and a reference rise fall in the same cycle, the violation wins. `locked` is cleared and the quiet count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Divided reference pulse train |
| fb_in | input | 1 | Divided oscillator (feedback) pulse train |
| quiet_need | input | QUIET_W | Consecutive quiet periods needed to declare lock |
| wide_limit | input | WIDTH_W | Longest pulse, in cycles, tolerated while locked |
| up_n | output | 1 | Active-low frequency-increase pulse |
| dn_n | output | 1 | Active-low frequency-decrease pulse |
| act_raw | output | 1 | Raw activity, NAND of `up_n` and `dn_n` |
| locked | output | 1 | Filtered lock flag |

## Verification
Two lock-filter functions can fall in the same clock cycle. One is the reference edge that closes a comparison period. The other is the cycle in which a down pulse crosses the width limit. The bench provokes this by leading the reference with the feedback edge by exactly `wide_limit`+1 cycles. The lagging reference rise then ends the pulse in the same cycle the width counter reaches the limit. A period-level arithmetic model expects the violation to win: `locked` must be 0 at the end of that period, and it must return only after a full run of quiet periods. The same sweep, over every offset in both directions, also judges the pulse widths and the exclusion of simultaneous up and down pulses.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_UP   = 2'd1,
        PH_DN   = 2'd2
    } ph_state_e;

    typedef struct packed {
        logic ref_rise;
        logic fb_rise;
    } edge_pair_t;

    localparam int unsigned CH_REF = 1;
    localparam int unsigned CH_FB  = 0;
    localparam int unsigned N_CH   = 2;

    // Detector transition: a rise on both inputs, whether already pending
    // or new, clears back to idle in the same cycle.
    function automatic ph_state_e ph_next(input ph_state_e s, input edge_pair_t e);
        ph_state_e n;
        n = s;
        case (s)
            PH_IDLE: begin
                if (e.ref_rise && !e.fb_rise)      n = PH_UP;
                else if (e.fb_rise && !e.ref_rise) n = PH_DN;
                else                               n = PH_IDLE;
            end
            PH_UP:   n = e.fb_rise  ? PH_IDLE : PH_UP;
            PH_DN:   n = e.ref_rise ? PH_IDLE : PH_DN;
            default: n = PH_IDLE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pfd_edge_sense.sv
module pfd_edge_sense #(
    parameter int unsigned CH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CH-1:0] lvl,
    output logic [CH-1:0] rise
);
    logic [CH-1:0] prev_q;

    for (genvar g = 0; g < CH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) prev_q[g] <= 1'b0;
            else     prev_q[g] <= lvl[g];
        end
        assign rise[g] = lvl[g] & ~prev_q[g];

        // R2: a level held high cannot report a second rise
        p_single_rise_r2: assert property (@(posedge clk) disable iff (rst)
            (rise[g] && lvl[g]) |=> !rise[g]);
    end

endmodule

// File: rtl/pfd_phase_core.sv
module pfd_phase_core
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  edge_pair_t edges,
    output logic       up_n,
    output logic       dn_n
);
    ph_state_e st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= PH_IDLE;
        else     st_q <= ph_next(st_q, edges);
    end

    assign up_n = (st_q != PH_UP);
    assign dn_n = (st_q != PH_DN);

    // R3: a lone reference rise from idle opens an up pulse
    p_up_open_r3: assert property (@(posedge clk) disable iff (rst)
        (up_n && dn_n && edges.ref_rise && !edges.fb_rise) |=> !up_n);

    // R4: a held down pulse lasts until the reference rises
    p_dn_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!dn_n && !edges.ref_rise) |=> !dn_n);

    // R5: coincident rises from idle leave both outputs inactive
    p_tie_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (up_n && dn_n && edges.ref_rise && edges.fb_rise) |=> (up_n && dn_n));

    // R6: further reference rises do not end an up pulse
    p_up_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!up_n && !edges.fb_rise) |=> !up_n);

    // R3: the feedback rise ends an up pulse
    p_up_close_r3: assert property (@(posedge clk) disable iff (rst)
        (!up_n && edges.fb_rise) |=> up_n);

endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter #(
    parameter int unsigned QUIET_W = 8,
    parameter int unsigned WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_rise,
    input  logic               act,
    input  logic [QUIET_W-1:0] quiet_need,
    input  logic [WIDTH_W-1:0] wide_limit,
    output logic               locked
);
    localparam logic [QUIET_W-1:0] Q_MAX = {QUIET_W{1'b1}};
    localparam logic [WIDTH_W-1:0] W_MAX = {WIDTH_W{1'b1}};
    localparam logic [QUIET_W-1:0] Q_ONE = QUIET_W'(1);

    logic [WIDTH_W-1:0] wid_q;
    logic [QUIET_W-1:0] quiet_q;
    logic               seen_q;
    logic               too_wide;
    logic               period_quiet;
    logic [QUIET_W-1:0] quiet_inc;
    logic [QUIET_W-1:0] need_eff;

    assign too_wide     = act && (wid_q >= wide_limit);
    assign period_quiet = !(seen_q || act);
    assign quiet_inc    = (quiet_q == Q_MAX) ? quiet_q : quiet_q + Q_ONE;
    assign need_eff     = (quiet_need == '0) ? Q_ONE : quiet_need;

    always_ff @(posedge clk) begin
        if (rst) begin
            wid_q   <= '0;
            quiet_q <= '0;
            seen_q  <= 1'b0;
            locked  <= 1'b0;
        end else begin
            if (!act)              wid_q <= '0;
            else if (wid_q != W_MAX) wid_q <= wid_q + WIDTH_W'(1);

            seen_q <= ref_rise ? 1'b0 : (seen_q | act);

            if (too_wide) begin
                quiet_q <= '0;
                locked  <= 1'b0;
            end else if (ref_rise) begin
                if (period_quiet) begin
                    quiet_q <= quiet_inc;
                    if (quiet_inc >= need_eff) locked <= 1'b1;
                end else begin
                    quiet_q <= '0;
                end
            end
        end
    end

    // R8: lock can only rise right after a reference rise
    p_lock_on_ref_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(ref_rise));

    // R9: a pulse past the width limit drops the lock
    p_wide_drop_r9: assert property (@(posedge clk) disable iff (rst)
        too_wide |=> !locked);

    // R10: a violation coinciding with a reference rise zeroes the count
    p_wide_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (too_wide && ref_rise) |=> (quiet_q == '0 && !locked));

endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top
    import pfd_pkg::*;
#(
    parameter int unsigned QUIET_W = 8,
    parameter int unsigned WIDTH_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_in,
    input  logic               fb_in,
    input  logic [QUIET_W-1:0] quiet_need,
    input  logic [WIDTH_W-1:0] wide_limit,
    output logic               up_n,
    output logic               dn_n,
    output logic               act_raw,
    output logic               locked
);
    logic [N_CH-1:0] lvl;
    logic [N_CH-1:0] rise;
    edge_pair_t      edges;

    assign lvl[CH_REF] = ref_in;
    assign lvl[CH_FB]  = fb_in;

    pfd_edge_sense #(.CH(N_CH)) edge_i (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .rise (rise)
    );

    assign edges.ref_rise = rise[CH_REF];
    assign edges.fb_rise  = rise[CH_FB];

    pfd_phase_core core_i (
        .clk   (clk),
        .rst   (rst),
        .edges (edges),
        .up_n  (up_n),
        .dn_n  (dn_n)
    );

    assign act_raw = ~(up_n & dn_n);

    pfd_lock_filter #(.QUIET_W(QUIET_W), .WIDTH_W(WIDTH_W)) lock_i (
        .clk        (clk),
        .rst        (rst),
        .ref_rise   (edges.ref_rise),
        .act        (act_raw),
        .quiet_need (quiet_need),
        .wide_limit (wide_limit),
        .locked     (locked)
    );

    // R5: the two request outputs are never active together
    p_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(!up_n && !dn_n));

    // R1: the cycle after reset shows an idle detector and no lock
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (up_n && dn_n && !locked));

endmodule

// File: tb/pfd_lock_top_tb_top.sv
`timescale 1ns/1ps
module pfd_lock_top_tb_top;
    localparam int QW = 8;
    localparam int WW = 8;
    localparam int P  = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_in = 1'b0;
    logic          fb_in  = 1'b0;
    logic [QW-1:0] quiet_need = '0;
    logic [WW-1:0] wide_limit = '0;
    logic          up_n, dn_n, act_raw, locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // window results
    int upc, dnc, both, actbad;
    bit lk_end;

    // period-level model of the lock filter
    int  m_q;
    bit  m_lk;
    bit  m_pend;
    int  m_need;
    int  m_w;

    always #4 clk = ~clk;

    pfd_lock_top #(.QUIET_W(QW), .WIDTH_W(WW)) dut_i (
        .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
        .quiet_need(quiet_need), .wide_limit(wide_limit),
        .up_n(up_n), .dn_n(dn_n), .act_raw(act_raw), .locked(locked)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit hit(input int t, input int x, input int hold);
        return (x >= 0) && (t >= x) && (t < x + hold);
    endfunction

    task automatic do_reset(input int need, input int lim);
        @(negedge clk);
        rst = 1'b1; ref_in = 1'b0; fb_in = 1'b0;
        quiet_need = QW'(need); wide_limit = WW'(lim);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_q = 0; m_lk = 1'b0; m_pend = 1'b0;
        m_need = (need == 0) ? 1 : need;
        m_w = lim;
    endtask

    // one window of P cycles; sample first, then drive
    task automatic run_window(input int ra, input int rb, input int fa, input int fb2, input int hold);
        upc = 0; dnc = 0; both = 0; actbad = 0; lk_end = 1'b0;
        for (int t = 0; t < P; t++) begin
            @(negedge clk);
            if (!up_n) upc++;
            if (!dn_n) dnc++;
            if (!up_n && !dn_n) both++;
            if (act_raw != !(up_n && dn_n)) actbad++;
            if (t == P - 1) lk_end = locked;
            ref_in = hit(t, ra, hold) | hit(t, rb, hold);
            fb_in  = hit(t, fa, hold) | hit(t, fb2, hold);
        end
    endtask

    task automatic run_period(input int d);
        int  mag;
        bit  noisy, wide;
        mag = (d < 0) ? -d : d;
        if (d >= 0) run_window(0, -1, d, -1, 1);
        else         run_window(-d, -1, 0, -1, 1);
        chk(upc == ((d > 0) ? d : 0), "R3 up width", upc, (d > 0) ? d : 0);
        chk(dnc == ((d < 0) ? -d : 0), "R4 dn width", dnc, (d < 0) ? -d : 0);
        chk(both == 0, "R5 both low", both, 0);
        if (d == 0) chk(upc + dnc == 0, "R5 tie pulse", upc + dnc, 0);
        chk(actbad == 0, "R7 nand", actbad, 0);
        // model
        noisy = m_pend || (d < 0);
        wide  = mag > m_w;
        if (!noisy) begin
            m_q = (m_q < 255) ? m_q + 1 : m_q;
            if (m_q >= m_need) m_lk = 1'b1;
        end else begin
            m_q = 0;
        end
        if (wide) begin m_lk = 1'b0; m_q = 0; end
        m_pend = (d > 0);
        if (d < 0 && mag == m_w + 1)
            chk(lk_end == m_lk, "R10 lock", int'(lk_end), int'(m_lk));
        else if (wide)
            chk(lk_end == m_lk, "R9 lock", int'(lk_end), int'(m_lk));
        else
            chk(lk_end == m_lk, "R8 lock", int'(lk_end), int'(m_lk));
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    errors++;
                    checks++;
                    $display("FAIL watchdog actual=1 expected=0");
                    $display("CHECKS %0d ERRORS %0d", checks, errors);
                    $finish;
                end
            end
        join_none

        // R1 reset state
        do_reset(3, 4);
        @(negedge clk);
        chk(up_n == 1'b1, "R1 up_n", int'(up_n), 1);
        chk(dn_n == 1'b1, "R1 dn_n", int'(dn_n), 1);
        chk(act_raw == 1'b0, "R1 act_raw", int'(act_raw), 0);
        chk(locked == 1'b0, "R1 locked", int'(locked), 0);

        // offset sweep in both directions with lock build-up between
        for (int rep = 0; rep < 2; rep++) begin
            for (int d = -8; d <= 8; d++) begin
                for (int k = 0; k < 4; k++) run_period(0);
                run_period(d);
            end
        end

        // R6: second reference rise while up is held
        do_reset(3, 4);
        run_window(0, 3, 7, -1, 1);
        chk(upc == 7, "R6 up over two ref rises", upc, 7);
        chk(dnc == 0, "R6 no dn", dnc, 0);
        run_window(6, -1, 0, 4, 1);
        chk(dnc == 6, "R6 dn over two fb rises", dnc, 6);
        chk(upc == 0, "R6 no up", upc, 0);

        // R2: levels held high start nothing further
        do_reset(3, 4);
        run_window(0, -1, 3, -1, 6);
        chk(upc == 3, "R2 held levels up", upc, 3);
        chk(dnc == 0, "R2 held levels dn", dnc, 0);

        // R8 need of zero acts as one; R9 and R10 with a small limit
        do_reset(0, 2);
        run_period(0);
        chk(lk_end == 1'b1, "R8 zero need", int'(lk_end), 1);
        run_period(3);
        run_period(0);
        run_period(0);
        run_period(-3);
        run_period(0);
        run_period(2);
        run_period(0);
        run_period(0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule